// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block is the slave end of a three-wire serial port. An external host uses it to read and write a small array of byte-wide configuration registers. The port has three signals: a serial clock, an active-low select, and a single data line that is shared by both directions. Because pads are outside this block, the shared line appears here as an input, an output and an output enable. All three serial signals are resynchronised into the system clock domain, and the block then detects their edges there.

Every frame opens with a 16-bit instruction. The instruction holds a direction flag, a two-bit length code and a 13-bit start address. One or more 8-bit data words follow it. For writes, the data words go into the register array. For reads, the block turns the line around and shifts out register contents.

The host may raise select at a byte boundary to pause a transfer, and the transfer then continues where it stopped. One length code gives an open-ended stream that runs until select rises. Bit 0 of register 0 chooses between MSB-first and LSB-first shifting for everything in a frame, including the instruction.

Top module: `spi3w_slave`

## Requirements
- R1: After reset, every register reads zero, `sdio_oe` is low and shifting is MSB-first.
- R2: In MSB-first mode, the instruction's first bit is the direction flag (1 = read, 0 = write). The next two bits are the length code, and the 13 bits after that are the start address, most significant bit first.
- R3: Length code 0, 1 and 2 transfer 1, 2 and 3 data bytes. SCLK pulses after the last counted byte change no register.
- R4: Length code 3 streams: bytes keep transferring until select rises.
- R5: In a multi-byte transfer the address moves by one per byte. It steps down in MSB-first mode and up in LSB-first mode, wrapping within 13 bits.
- R6: In a read, `sdio_oe` rises after the instruction. Each data bit is presented after an SCLK falling edge, or after a resuming select fall, and is held until the next such event. In MSB-first mode, bit 7 of each byte comes first.
- R7: `sdio_oe` is low during the instruction phase and whenever select is high.
- R8: Raising select at a byte boundary before the transfer is complete pauses the frame. The boundary may be after 8 instruction bits or between data bytes. The next select fall resumes at the same position, with no new instruction.
- R9: Writing 1 to bit 0 of register 0 makes later frames shift both instruction and data LSB-first. The change takes effect only from the next frame.
- R10: Addresses at or above the register count ignore writes and read as zero.
- R11: Raising select in the middle of a byte aborts the frame without writing the partial byte. The next select fall starts a new instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low select from the host |
| sdio_in | input | 1 | Line value seen at the pad |
| sdio_out | output | 1 | Read data to drive onto the line |
| sdio_oe | output | 1 | Drive enable for the line |
| cfg_regs | output | NUM_REGS*8 | All registers, register n at bits [8n+7:8n] |

## Verification
A read bit is valid three system clocks after the SCLK fall (or resuming select fall) that requests it: two resynchronising stages, then the output register. A register write lands within four clocks of the eighth SCLK rise of its byte, and `sdio_oe` drops within three clocks of select rising. The bench holds each SCLK half period for four clocks and samples read data on the last falling clock edge before it raises SCLK. It also waits six clocks after raising select before it compares the register outputs, so every check falls after its result is due and before the next stimulus.

// File: rtl/spi3w_pkg.sv
// Shared constants and types for the three-wire serial register slave.
// Assumes a fixed 16-bit instruction and 8-bit data words.
package spi3w_pkg;
    localparam int INSTR_BITS = 16;
    localparam int BYTE_BITS  = 8;
    localparam int ADDR_BITS  = 13;

    // Frame sequencing phases
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INSTR,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Instruction word as assembled after 16 bits
    typedef struct packed {
        logic                 rd;
        logic [1:0]           len;
        logic [ADDR_BITS-1:0] addr;
    } instr_t;

    localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi3w_sync.sv
// Multi-bit, multi-stage resynchroniser for slow asynchronous inputs.
// Assumes each bit is independent; the reset value is per bit.
module spi3w_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RESET_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RESET_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi3w_regfile.sv
// Byte-wide register array with one write port and one combinational
// read port. Out-of-range addresses ignore writes and read zero.
// Assumes NUM_REGS >= 2; one bit of register 0 selects LSB-first order.
module spi3w_regfile #(
    parameter int NUM_REGS  = 8,
    parameter int ADDR_W    = 13,
    parameter int ORDER_BIT = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  lsb_first
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];
    logic       rd_in_range;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Each register loads on a write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    // Read mux with zero for unimplemented addresses
    always_comb begin
        rd_in_range = rd_addr < LIMIT;
        rd_data     = rd_in_range ? regs[rd_addr[IDX_W-1:0]] : 8'h00;
    end

    assign lsb_first = regs[0][ORDER_BIT];
endmodule

// File: rtl/spi3w_frame.sv
// Frame engine: assembles the instruction, counts data bytes, steps the
// address, issues write pulses and shifts out read data.
// Assumes edge strobes are already qualified with select being low, and
// that select edges and SCLK edges never fall in the same system clock.
module spi3w_frame
    import spi3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 cs_fall,
    input  logic                 cs_rise,
    input  logic                 sdi,
    input  logic                 lsb_cfg,
    input  logic [7:0]           rd_data,
    output logic                 wr_en,
    output logic [ADDR_BITS-1:0] wr_addr,
    output logic [7:0]           wr_data,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 sdo,
    output logic                 sdo_en
);
    phase_e                 phase_q;
    logic                   lsb_q;
    logic [3:0]             cnt_q;
    logic [INSTR_BITS-1:0]  shift_q;
    logic                   rd_q;
    logic                   stream_q;
    logic [1:0]             left_q;
    logic [ADDR_BITS-1:0]   addr_q;
    logic                   wr_en_q;
    logic [ADDR_BITS-1:0]   wr_addr_q;
    logic [7:0]             wr_data_q;
    logic                   sdo_q;
    logic                   oe_q;

    logic [INSTR_BITS-1:0]  instr_nx;
    logic [7:0]             byte_nx;
    instr_t                 dec;
    logic [ADDR_BITS-1:0]   addr_step;
    logic                   can_stall;
    logic [2:0]             tx_idx;
    logic                   in_read;
    logic                   drive_ev;

    // Next-shift values, decode and stall eligibility
    always_comb begin
        instr_nx  = lsb_q ? {sdi, shift_q[INSTR_BITS-1:1]}
                          : {shift_q[INSTR_BITS-2:0], sdi};
        byte_nx   = lsb_q ? {sdi, shift_q[7:1]} : {shift_q[6:0], sdi};
        dec       = instr_t'(instr_nx);
        addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
        can_stall = (phase_q == PH_INSTR && cnt_q == 4'd8) ||
                    (phase_q == PH_DATA  && cnt_q == 4'd0 && !stream_q);
        tx_idx    = lsb_q ? cnt_q[2:0] : 3'd7 - cnt_q[2:0];
        in_read   = (phase_q == PH_DATA) && rd_q;
        drive_ev  = (sclk_fall || cs_fall) && in_read;
    end

    // Frame sequencing, instruction decode and byte reception
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            lsb_q     <= 1'b0;
            cnt_q     <= '0;
            shift_q   <= '0;
            rd_q      <= 1'b0;
            stream_q  <= 1'b0;
            left_q    <= '0;
            addr_q    <= '0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (cs_fall && phase_q == PH_IDLE) begin
                phase_q <= PH_INSTR;
                cnt_q   <= '0;
                shift_q <= '0;
                lsb_q   <= lsb_cfg;
            end else if (cs_rise && !can_stall) begin
                phase_q <= PH_IDLE;
            end else if (sclk_rise) begin
                case (phase_q)
                    PH_INSTR: begin
                        if (cnt_q == 4'(INSTR_BITS - 1)) begin
                            rd_q     <= dec.rd;
                            stream_q <= (dec.len == LEN_STREAM);
                            left_q   <= dec.len;
                            addr_q   <= dec.addr;
                            phase_q  <= PH_DATA;
                            cnt_q    <= '0;
                            shift_q  <= '0;
                        end else begin
                            shift_q <= instr_nx;
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (cnt_q == 4'(BYTE_BITS - 1)) begin
                            if (!rd_q) begin
                                wr_en_q   <= 1'b1;
                                wr_addr_q <= addr_q;
                                wr_data_q <= byte_nx;
                            end
                            addr_q  <= addr_step;
                            cnt_q   <= '0;
                            shift_q <= '0;
                            if (!stream_q) begin
                                if (left_q == 2'd0) phase_q <= PH_DONE;
                                else                left_q  <= left_q - 1'b1;
                            end
                        end else begin
                            shift_q <= {8'h00, byte_nx};
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read data launch and line drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (cs_rise) begin
            oe_q <= 1'b0;
        end else if (drive_ev) begin
            sdo_q <= rd_data[tx_idx];
            oe_q  <= 1'b1;
        end else if (sclk_fall && !in_read) begin
            oe_q <= 1'b0;
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign rd_addr = addr_q;
    assign sdo     = sdo_q;
    assign sdo_en  = oe_q & sel;
endmodule

// File: rtl/spi3w_slave.sv
// Top level of the three-wire serial register slave: resynchronises the
// serial pins, derives edge strobes and joins frame engine and registers.
// Assumes SCLK and select are slow against clk (at least 3 clk per level).
module spi3w_slave #(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  sdio_in,
    output logic                  sdio_out,
    output logic                  sdio_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    import spi3w_pkg::*;

    logic [2:0]           pins_s;
    logic                 sclk_s, cs_s, sdi_s;
    logic                 sclk_d, cs_d;
    logic                 sel, cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic                 wr_en;
    logic [ADDR_BITS-1:0] wr_addr, rd_addr;
    logic [7:0]           wr_data, rd_data;
    logic                 lsb_cfg;

    spi3w_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b010)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, sdio_in}),
        .q    (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_s   = pins_s[1];
    assign sdi_s  = pins_s[0];

    // Previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    // Edge strobes, SCLK qualified by select
    always_comb begin
        sel       = ~cs_s;
        cs_fall   = cs_d & ~cs_s;
        cs_rise   = ~cs_d & cs_s;
        sclk_rise = sel & sclk_s & ~sclk_d;
        sclk_fall = sel & ~sclk_s & sclk_d;
    end

    spi3w_frame i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sdi      (sdi_s),
        .lsb_cfg  (lsb_cfg),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .sdo      (sdio_out),
        .sdo_en   (sdio_oe)
    );

    spi3w_regfile #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_BITS),
        .ORDER_BIT(0)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .regs_flat(cfg_regs),
        .lsb_first(lsb_cfg)
    );
endmodule

// File: rtl/spi3w_chk.sv
// Property checker for the serial register slave, bound to its top.
// Assumes the bound instance exposes its internal edge strobes.
module spi3w_chk #(
    parameter int REG_BITS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                sdio_out,
    input logic                sdio_oe,
    input logic [REG_BITS-1:0] cfg_regs,
    input logic                wr_en,
    input logic                sel,
    input logic                sclk_fall,
    input logic                cs_fall
);
    logic [2:0] cyc_q;

    // Saturating count of cycles since reset release
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_regs == '0 && !sdio_oe));

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd7 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !sdio_oe);

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall || cs_fall) |=> $stable(sdio_out));

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    // R11
    no_write_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 3'd0 && !sel && $past(!sel)) |-> !wr_en);
endmodule

bind spi3w_slave spi3w_chk #(.REG_BITS(NUM_REGS * 8)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdio_out (sdio_out),
    .sdio_oe  (sdio_oe),
    .cfg_regs (cfg_regs),
    .wr_en    (wr_en),
    .sel      (sel),
    .sclk_fall(sclk_fall),
    .cs_fall  (cs_fall)
);

// File: tb/test_spi3w_slave.sv
module test_spi3w_slave;
    localparam int NREG = 8;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_in = 1'b0;
    wire  sdio_out, sdio_oe;
    wire  [NREG*8-1:0] cfg_regs;

    int n_tests = 0, n_fail = 0;
    logic [7:0] mdl [0:NREG-1];
    logic [7:0] dbuf [0:7];
    logic [7:0] rbuf [0:7];

    always #10 clk = ~clk;

    spi3w_slave #(.NUM_REGS(NREG)) i_spi3w_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .cfg_regs(cfg_regs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < NREG; a++) check(tag, 32'(cfg_regs[a*8 +: 8]), 32'(mdl[a]));
    endtask

    function automatic logic [12:0] step(input logic [12:0] a, input int k, input logic lsb);
        return lsb ? a + 13'(k) : a - 13'(k);
    endfunction

    task automatic bit_out(input logic b);
        sdio_in = b;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        repeat (4) @(negedge clk);
        b = sdio_out;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] w, input int nb, input int first, input int cnt, input logic lsb);
        for (int i = first; i < first + cnt; i++) bit_out(lsb ? w[i] : w[nb-1-i]);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_instr(input logic rd, input logic [1:0] len, input logic [12:0] a,
                              input logic lsb, input bit split);
        logic [15:0] w = {rd, len, a};
        if (split) begin
            send_bits(w, 16, 0, 8, lsb);
            cs_hi();
            cs_lo();
            send_bits(w, 16, 8, 8, lsb);
        end else begin
            send_bits(w, 16, 0, 16, lsb);
        end
    endtask

    // Write frame: n bytes from dbuf; stall_at -1 none, 0 mid-instruction, k before byte k
    task automatic wr_frame(input logic [12:0] a, input logic [1:0] len, input int n,
                            input logic lsb, input int stall_at);
        int cnt;
        cs_lo();
        send_instr(1'b0, len, a, lsb, stall_at == 0);
        for (int k = 0; k < n; k++) begin
            if (k > 0 && k == stall_at) begin cs_hi(); cs_lo(); end
            send_bits({8'h00, dbuf[k]}, 8, 0, 8, lsb);
        end
        cs_hi();
        cnt = (len == 2'b11) ? n : ((n < int'(len) + 1) ? n : int'(len) + 1);
        for (int k = 0; k < cnt; k++) begin
            logic [12:0] ad = step(a, k, lsb);
            if (ad < 13'(NREG)) mdl[ad[2:0]] = dbuf[k];
        end
    endtask

    // Read frame into rbuf; also checks the drive enable around the turnaround
    task automatic rd_frame(input logic [12:0] a, input logic [1:0] len, input int n,
                            input logic lsb, input int stall_at);
        logic b;
        cs_lo();
        check("R7 oe low before instruction", 32'(sdio_oe), 32'd0);
        send_instr(1'b1, len, a, lsb, 1'b0);
        repeat (4) @(negedge clk);
        check("R6 oe high after instruction", 32'(sdio_oe), 32'd1);
        for (int k = 0; k < n; k++) begin
            if (k > 0 && k == stall_at) begin
                cs_hi();
                check("R7 oe low while deselected", 32'(sdio_oe), 32'd0);
                cs_lo();
            end
            for (int i = 0; i < 8; i++) begin
                bit_in(b);
                if (lsb) rbuf[k][i] = b; else rbuf[k][7-i] = b;
            end
        end
        cs_hi();
        check("R7 oe low after frame", 32'(sdio_oe), 32'd0);
    endtask

    task automatic check_read(input string tag, input logic [12:0] a, input int n, input logic lsb);
        for (int k = 0; k < n; k++) begin
            logic [12:0] ad = step(a, k, lsb);
            check(tag, 32'(rbuf[k]), (ad < 13'(NREG)) ? 32'(mdl[ad[2:0]]) : 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < NREG; a++) mdl[a] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 regs zero", 32'(cfg_regs == '0), 32'd1);
        check("R1 oe low", 32'(sdio_oe), 32'd0);

        // R2 / R10: single-byte write sweep over every address incl. out of range
        for (int a = 0; a < NREG + 2; a++) begin
            dbuf[0] = 8'((a * 37 + 10) & 8'hFE);
            wr_frame(13'(a), 2'b00, 1, 1'b0, -1);
        end
        check_regs("R2 R10 write sweep");
        for (int a = 0; a < NREG + 2; a++) begin
            rd_frame(13'(a), 2'b00, 1, 1'b0, -1);
            check_read("R2 R6 R10 read sweep", 13'(a), 1, 1'b0);
        end

        // R3 / R5: three-byte write steps down
        dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h96;
        wr_frame(13'd6, 2'b10, 3, 1'b0, -1);
        check_regs("R3 R5 three-byte write");
        // R3: extra byte after a one-byte count is ignored
        dbuf[0] = 8'h5A; dbuf[1] = 8'hFF;
        wr_frame(13'd3, 2'b00, 2, 1'b0, -1);
        check_regs("R3 extra clocks ignored");
        rd_frame(13'd6, 2'b01, 2, 1'b0, -1);
        check_read("R3 R5 two-byte read", 13'd6, 2, 1'b0);

        // R4: streaming write of five bytes, streaming read of six
        dbuf[0] = 8'h11; dbuf[1] = 8'h82; dbuf[2] = 8'h43; dbuf[3] = 8'hC4; dbuf[4] = 8'h25;
        wr_frame(13'd7, 2'b11, 5, 1'b0, -1);
        check_regs("R4 stream write");
        rd_frame(13'd5, 2'b11, 6, 1'b0, -1);
        check_read("R4 R5 stream read", 13'd5, 6, 1'b0);

        // R8: stall inside instruction and between data bytes
        dbuf[0] = 8'hE1; dbuf[1] = 8'h7E;
        wr_frame(13'd4, 2'b01, 2, 1'b0, 0);
        check_regs("R8 instruction stall");
        dbuf[0] = 8'h19; dbuf[1] = 8'hD2;
        wr_frame(13'd4, 2'b01, 2, 1'b0, 1);
        check_regs("R8 data stall write");
        rd_frame(13'd2, 2'b01, 2, 1'b0, 1);
        check_read("R8 data stall read", 13'd2, 2, 1'b0);

        // R11: abort mid-byte, then a fresh frame
        cs_lo();
        send_instr(1'b0, 2'b00, 13'd1, 1'b0, 1'b0);
        send_bits(16'h00FF, 8, 0, 4, 1'b0);
        cs_hi();
        check_regs("R11 partial byte dropped");
        rd_frame(13'd1, 2'b00, 1, 1'b0, -1);
        check_read("R11 new frame after abort", 13'd1, 1, 1'b0);

        // R9: switch to LSB-first; applies from next frame
        dbuf[0] = 8'h01;
        wr_frame(13'd0, 2'b00, 1, 1'b0, -1);
        check_regs("R9 order bit written");
        dbuf[0] = 8'h2C; dbuf[1] = 8'hB1;
        wr_frame(13'd2, 2'b01, 2, 1'b1, -1);
        check_regs("R9 R5 LSB write steps up");
        rd_frame(13'd2, 2'b01, 2, 1'b1, -1);
        check_read("R9 LSB read", 13'd2, 2, 1'b1);
        // Clearing the order bit keeps LSB order for the rest of this frame
        dbuf[0] = 8'h00; dbuf[1] = 8'h4D;
        wr_frame(13'd0, 2'b11, 2, 1'b1, -1);
        check_regs("R9 change deferred to next frame");
        rd_frame(13'd1, 2'b00, 1, 1'b0, -1);
        check_read("R9 back to MSB order", 13'd1, 1, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule